// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache placed between a CPU load/store port and a backing memory that moves whole blocks. The address is 12 bits wide. The cache holds 256 bytes as 32-byte lines in four sets of two ways. Each request is split into its fields, and both ways of the selected set are compared in the same cycle. A hit completes without delay. For a read hit the addressed 32-bit word appears on `cpu_rdata`. A miss holds `cpu_stall` high while the line is brought in from memory.

Stores use write-back with write-allocate. A store that hits changes only the cached copy and marks the line dirty. A store that misses first has its block fetched. The store is then replayed through the hit path, which merges the bytes and sets the dirty bit. A victim is chosen only when both ways of the set are valid. It is the way other than the one most recently used, tracked by one bit per set. A dirty victim is written back in full before the refill read is issued.

The control sequencer has three states:
- LOOKUP: idle and compare.
- EVICT: write-back of a dirty victim.
- REFILL: block read.

Its transitions are:
- LOOKUP→EVICT on a miss with a dirty victim.
- LOOKUP→REFILL on a miss with a clean or empty victim.
- EVICT→REFILL when memory accepts the write.
- REFILL→LOOKUP when memory returns the block.
- Every other case stays in the current state.

Top module: `cache_wb2way`

## Requirements
- R1: Address bits [4:0] are the byte offset and bits [6:5] the set index. Bits [11:7] are the tag. Bits [4:2] pick the 32-bit word in the line, and bits [1:0] are ignored. Memory addresses carry the set index in bits [6:5] and zeros in bits [4:0].
- R2: A request hits when either way of the indexed set is valid with an equal tag. On a hit `cpu_stall` stays low in that cycle. On a read hit `cpu_rdata` carries the addressed word.
- R3: After reset every line is invalid, `cpu_stall` and `mem_req` are low, and the first access to any block misses.
- R4: On a miss an invalid way is filled first, with way 0 taken before way 1.
- R5: When both ways are valid, the refilled way is the one not most recently used. A hit or a fill marks its way as most recently used.
- R6: A store hit writes only the bytes whose `cpu_be` bit is set (bit n covers data bits 8n+7:8n). It marks the line dirty and issues no memory request.
- R7: A store miss fetches the whole block, then merges the store data into it and marks the line dirty.
- R8: A dirty victim is written to memory first. The write has `mem_we`=1, the victim's own tag and index, and the full line. A read of the new block follows. A clean or invalid victim causes no memory write.
- R9: `mem_req`, `mem_we` and `mem_addr` stay steady until a cycle with `mem_ready` high, which completes that transfer.
- R10: `cpu_stall` is high from the miss until the access completes. Completion comes in the cycle after the refill transfer, in which the access hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 12 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid when not stalled |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write block, 0 = read block |
| mem_addr | output | 12 | Block-aligned memory address |
| mem_wdata | output | 256 | Block written back |
| mem_ready | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 256 | Block returned by memory |

## Verification
The assertions assume the CPU keeps `cpu_req`, `cpu_addr`, `cpu_we`, `cpu_wdata` and `cpu_be` constant for as long as `cpu_stall` is high. They also assume memory raises `mem_ready` only while a request is pending. The stimulus is built to stay within these assumptions. Each access in the bench is driven by one task that holds the request until the cycle it completes. The memory responder answers only after it has seen `mem_req` and holds `mem_ready` for a single cycle. It inserts random wait cycles so that the hold rule is exercised.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int ADDR_W     = 12;
    localparam int CAP_BYTES  = 256;
    localparam int LINE_BYTES = 32;
    localparam int WAYS       = 2;
    localparam int WORD_W     = 32;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SETS   = CAP_BYTES / LINE_BYTES / WAYS;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WPL    = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WPL);
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } cstate_t;
endpackage

// File: rtl/cwb_tags.sv
module cwb_tags
    import cwb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             touch_en,
    input  logic             touch_dirty,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic             sel_way,
    output logic             hit,
    output logic             hit_way,
    output logic             vic_way,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] sel_tag
);
    logic [WAYS-1:0]  match;
    logic [WAYS-1:0]  way_valid;
    logic [WAYS-1:0]  way_dirty;
    logic [TAG_W-1:0] way_tag [WAYS];
    logic [SETS-1:0]  mru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (fill_en && fill_way == 1'(w)) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end else if (touch_en && touch_dirty && touch_way == 1'(w)) begin
                dirty_q[idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w)) tag_q[idx] <= tag;
        end

        assign way_valid[w] = valid_q[idx];
        assign way_dirty[w] = dirty_q[idx];
        assign way_tag[w]   = tag_q[idx];
        assign match[w]     = valid_q[idx] && (tag_q[idx] == tag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mru_q      <= '0;
        else if (fill_en)  mru_q[idx] <= fill_way;
        else if (touch_en) mru_q[idx] <= touch_way;
    end

    assign hit     = |match;
    assign hit_way = match[1];

    always_comb begin
        if (!way_valid[0])      vic_way = 1'b0;
        else if (!way_valid[1]) vic_way = 1'b1;
        else                    vic_way = ~mru_q[idx];
        vic_dirty = way_dirty[vic_way];
        sel_tag   = way_tag[sel_way];
    end
endmodule

// File: rtl/cwb_data.sv
module cwb_data
    import cwb_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    input  logic              rd_way,
    input  logic              sel_way,
    output logic [WORD_W-1:0] rd_word,
    output logic [LINE_W-1:0] sel_line
);
    logic [LINE_W-1:0] way_line [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_W-1:0] lines [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w)) begin
                lines[idx] <= fill_line;
            end else if (wr_en && wr_way == 1'(w)) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (be[b]) lines[idx][int'(wsel)*WORD_W + b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end

        assign way_line[w] = lines[idx];
    end

    assign rd_word  = way_line[rd_way][int'(wsel)*WORD_W +: WORD_W];
    assign sel_line = way_line[sel_way];
endmodule

// File: rtl/cwb_fsm.sv
module cwb_fsm
    import cwb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_req,
    input  logic    hit,
    input  logic    vic_way,
    input  logic    vic_dirty,
    input  logic    mem_ready,
    output cstate_t state,
    output logic    way_q,
    output logic    mem_req,
    output logic    mem_we,
    output logic    fill_en,
    output logic    stall,
    output logic    hit_go
);
    cstate_t next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOOKUP;
            way_q <= 1'b0;
        end else begin
            state <= next;
            if (state == ST_LOOKUP && cpu_req && !hit) way_q <= vic_way;
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_LOOKUP: if (cpu_req && !hit) next = vic_dirty ? ST_EVICT : ST_REFILL;
            ST_EVICT:  if (mem_ready) next = ST_REFILL;
            ST_REFILL: if (mem_ready) next = ST_LOOKUP;
            default:   next = ST_LOOKUP;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        fill_en = 1'b0;
        hit_go  = 1'b0;
        stall   = 1'b1;
        unique case (state)
            ST_LOOKUP: begin
                hit_go = cpu_req && hit;
                stall  = cpu_req && !hit;
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                fill_en = mem_ready;
            end
            default: stall = 1'b1;
        endcase
    end
endmodule

// File: rtl/cache_wb2way.sv
module cache_wb2way
    import cwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;
    logic              hit, hit_way, vic_way, vic_dirty, way_q, fill_en, hit_go;
    logic [TAG_W-1:0]  sel_tag;
    cstate_t           state;

    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_wsel = cpu_addr[OFF_W-1 -: WSEL_W];

    cwb_tags u_tags (
        .clk(clk), .rst_n(rst_n), .idx(a_idx), .tag(a_tag),
        .touch_en(hit_go), .touch_dirty(cpu_we), .touch_way(hit_way),
        .fill_en(fill_en), .fill_way(way_q), .sel_way(way_q),
        .hit(hit), .hit_way(hit_way), .vic_way(vic_way),
        .vic_dirty(vic_dirty), .sel_tag(sel_tag)
    );

    cwb_data u_data (
        .clk(clk), .idx(a_idx), .fill_en(fill_en), .fill_way(way_q),
        .fill_line(mem_rdata), .wr_en(hit_go && cpu_we), .wr_way(hit_way),
        .wsel(a_wsel), .wdata(cpu_wdata), .be(cpu_be), .rd_way(hit_way),
        .sel_way(way_q), .rd_word(cpu_rdata), .sel_line(mem_wdata)
    );

    cwb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .hit(hit),
        .vic_way(vic_way), .vic_dirty(vic_dirty), .mem_ready(mem_ready),
        .state(state), .way_q(way_q), .mem_req(mem_req), .mem_we(mem_we),
        .fill_en(fill_en), .stall(cpu_stall), .hit_go(hit_go)
    );

    assign mem_addr = {(state == ST_EVICT) ? sel_tag : a_tag, a_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/cwb_chk.sv
module cwb_chk
    import cwb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready
);
    p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready |=> mem_req && !mem_we);

    p_done_after_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> !cpu_stall);

    p_stall_during_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);

    p_mem_set_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[OFF_W +: IDX_W] == cpu_addr[OFF_W +: IDX_W]);

    p_hit_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_stall |-> !mem_req);
endmodule

bind cache_wb2way cwb_chk i_chk (.*);

// File: tb/test_cache_wb2way.sv
module test_cache_wb2way;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_stall, mem_req, mem_we;
    logic [11:0]  mem_addr;
    logic [255:0] mem_wdata;
    logic         mem_ready = 1'b0;
    logic [255:0] mem_rdata = '0;

    int checks = 0, errors = 0;

    // bench model
    logic [255:0] bmem [128];
    logic [255:0] m_line [4][2];
    logic [4:0]   m_tag [4][2];
    bit           m_val [4][2];
    bit           m_dty [4][2];
    bit           m_mru [4];

    always #10 clk = ~clk;

    cache_wb2way i_cache_wb2way (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input int t, input int s, input int w);
        return {5'(t), 2'(s), 3'(w), 2'b0};
    endfunction

    // one memory transfer; entered and left at negedge+2
    task automatic mem_xfer(input bit we, input logic [11:0] a, input logic [255:0] wexp);
        int d = $urandom_range(0, 2);
        chk(mem_req === 1'b1, "R8", "mem_req", 256'(mem_req), 1);
        chk(mem_we === we, "R8", "mem_we", 256'(mem_we), 256'(we));
        chk(mem_addr === a, "R8", "mem_addr", 256'(mem_addr), 256'(a));
        for (int i = 0; i < d; i++) begin
            @(negedge clk); #2;
            chk(mem_req === 1'b1 && mem_we === we && mem_addr === a, "R9", "hold",
                256'(mem_addr), 256'(a));
        end
        if (we) begin
            chk(mem_wdata === wexp, "R8", "writeback data", mem_wdata, wexp);
            bmem[a[11:5]] = mem_wdata;
        end
        mem_rdata = bmem[a[11:5]];
        mem_ready = 1'b1;
        @(posedge clk); #1;
        mem_ready = 1'b0;
        @(negedge clk); #2;
    endtask

    task automatic access(input bit we, input logic [11:0] a, input logic [31:0] wd,
                          input logic [3:0] be);
        int t = a[11:7], s = a[6:5], w = a[4:2], way;
        bit hit = 0;
        logic [31:0] word;
        for (int k = 0; k < 2; k++) if (m_val[s][k] && m_tag[s][k] == 5'(t)) begin hit = 1; way = k; end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        #2;
        if (!hit) begin
            way = !m_val[s][0] ? 0 : !m_val[s][1] ? 1 : int'(!m_mru[s]);
            chk(cpu_stall === 1'b1, "R3", "miss stall", 256'(cpu_stall), 1);
            @(negedge clk); #2;
            if (m_val[s][way] && m_dty[s][way])
                mem_xfer(1'b1, {m_tag[s][way], 2'(s), 5'b0}, m_line[s][way]);
            mem_xfer(1'b0, {5'(t), 2'(s), 5'b0}, '0);
            m_line[s][way] = bmem[a[11:5]];
            m_tag[s][way] = 5'(t); m_val[s][way] = 1; m_dty[s][way] = 0; m_mru[s] = way[0];
        end
        chk(cpu_stall === 1'b0, hit ? "R2" : "R10", "stall at completion", 256'(cpu_stall), 0);
        chk(mem_req === 1'b0, "R6", "no mem on hit", 256'(mem_req), 0);
        word = m_line[s][way][w*32 +: 32];
        if (!we) chk(cpu_rdata === word, hit ? "R2" : "R4", "read data", 256'(cpu_rdata), 256'(word));
        else begin
            for (int b = 0; b < 4; b++) if (be[b]) word[b*8 +: 8] = wd[b*8 +: 8];
            m_line[s][way][w*32 +: 32] = word;
            m_dty[s][way] = 1;
        end
        m_mru[s] = way[0];
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 128; i++)
            for (int j = 0; j < 8; j++)
                bmem[i][j*32 +: 32] = 32'(i) * 32'h0100_0193 + 32'(j) * 32'h1111 + 32'h5A5A_0000;
        for (int s = 0; s < 4; s++) begin
            m_mru[s] = 0;
            for (int k = 0; k < 2; k++) begin m_val[s][k] = 0; m_dty[s][k] = 0; end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        chk(cpu_stall === 1'b0, "R3", "reset stall", 256'(cpu_stall), 0);
        chk(mem_req === 1'b0, "R3", "reset mem_req", 256'(mem_req), 0);

        // directed: R4 fill order, R5 victim choice, R8 write-back, R7 write miss, R1 ignored low bits
        access(0, mk(1, 1, 3), 0, 0);                 // R4 cold fill way0
        access(0, mk(2, 1, 0), 0, 0);                 // R4 fill way1
        access(0, mk(1, 1, 5) | 12'h3, 0, 0);         // R1 low bits ignored, R2 hit
        access(1, mk(2, 1, 2), 32'hDEAD_BEEF, 4'b0101); // R6 write hit
        access(0, mk(2, 1, 2), 0, 0);                 // R6 merged bytes
        access(0, mk(3, 1, 0), 0, 0);                 // R5 evict clean way0
        access(0, mk(4, 1, 0), 0, 0);                 // R8 evict dirty way1
        access(1, mk(7, 2, 7), 32'hCAFE_F00D, 4'b1111); // R7 write miss
        access(0, mk(7, 2, 7), 0, 0);                 // R7 merged
        access(0, mk(8, 2, 0), 0, 0);
        access(0, mk(9, 2, 0), 0, 0);                 // R8 dirty line written back

        for (int n = 0; n < 600; n++)
            access(1'($urandom_range(0, 1)), mk($urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 7)) | 12'($urandom_range(0, 3)),
                   $urandom, 4'($urandom_range(0, 15)));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule